// File: doc/BRIEF.md
# Sequence-and-CRC checked packet FIFO

This block takes 32-bit configuration words from a producer one word per cycle and keeps each packet in internal storage until the packet's closing check word has arrived. A packet opens with a header word carrying its payload length and a rolling 8-bit sequence number. The payload words follow, and then a CRC32 word that covers the header and the payload. A packet becomes visible to the consumer only when the header is well formed, the sequence number is the expected one and the CRC matches. The header and payload words then leave in order on a valid/ready read port. The check word itself is never forwarded.

Level flags tell the producer how much room is left. Any failure raises an error flag that stays set: a bad header, a sequence or CRC mismatch, a write while full, or a pop while nothing is readable. Once the flag is set, forwarding stops. The load input frames the whole transfer. While it is low, the block is held cleared. When it rises, a new transfer starts with sequence number 0.

Top module: `cfg_pkt_fifo`

## Requirements
- R1: After load rises, the first accepted packet carries sequence 0. Each later packet carries the previous value plus one, modulo 256 (255 is followed by 0). Any other value sets err.
- R2: A header word holds the payload length in words in bits [9:0] (legal range 1 to 511) and the sequence number in bits [17:10]. Bits [31:18] must be zero. A length of 0, a length above 511 or any nonzero upper bit sets err.
- R3: The word after the last payload word is the check word. It must equal the bitwise inverse of a CRC32 run over the header and the payload words. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF, and shifts in each word from bit 0 upward. None of a packet's words become readable before a matching check word has been written. The check word is not stored.
- R4: When a check word does not match, err is set and all stored words of that packet are released. The freed space shows on the low and full flags.
- R5: rd_valid is high when a committed word is waiting. rd_data then shows the oldest committed word, header first, and it holds steady until rd_ready is high in a cycle where rd_valid is high.
- R6: full is high when 1023 or more words are stored. A write while full is dropped and sets err.
- R7: low is high when the free space is at least 512 words, that is, when at most 512 words are stored.
- R8: rd_ready high in a cycle where rd_valid is low is an underflow and sets err.
- R9: err stays high until load falls. While err is high, rd_valid stays low and writes are not stored.
- R10: A clock edge with load low clears the block: err, rd_valid and full go low, low goes high, and the expected sequence number returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| load | input | 1 | High for a whole transfer; low holds the block cleared |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Header, payload or check word |
| full | output | 1 | Storage holds 1023 or more words |
| low | output | 1 | At least 512 words are free |
| rd_ready | input | 1 | Consumer takes the word offered on rd_data |
| rd_valid | output | 1 | A committed word is offered |
| rd_data | output | 32 | Oldest committed word |
| err | output | 1 | Sticky error flag |

## Verification
The bench builds the block with its default parameters: 1024 words of storage, a 511-word payload limit and a 512-word low threshold. With these values, two back-to-back maximum packets, written with the reader idle, drive the store across the low threshold and into the 1023-word full point, so an overflow is reached within about a thousand cycles. A run of 257 one-word packets carries the 8-bit sequence counter through its wrap. A rejected 511-word packet shows its rewind as the low flag returning high.

// File: rtl/cfg_pkt_fifo.sv
module cfg_pkt_fifo #(
  parameter int AW        = 10,
  parameter int LEN_MAX   = 511,
  parameter int LOW_WORDS = 512
) (
  input  logic        clk,
  input  logic        load,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        full,
  output logic        low,
  input  logic        rd_ready,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        err
);
  localparam int         DEPTH    = 1 << AW;
  localparam int         LW       = $clog2(LEN_MAX + 1);
  localparam logic [AW:0] FULL_AT = (AW+1)'(DEPTH - 1);
  localparam logic [AW:0] LOW_MAX = (AW+1)'(DEPTH - LOW_WORDS);
  localparam logic [9:0]  LEN_LIM = 10'(LEN_MAX);

  typedef enum logic [1:0] {S_HDR, S_PAY, S_CHK} ph_t;

  logic [31:0]   mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, cm_ptr, used;
  logic [LW-1:0] rem;
  logic [7:0]    seq;
  logic [31:0]   crc, crc_nx;
  ph_t           ph;

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++)
      r = (r >> 1) ^ (((r[0] ^ d[i]) != 1'b0) ? 32'hEDB88320 : 32'h0);
    return r;
  endfunction

  wire [9:0] h_len = wr_data[9:0];
  wire       h_ok  = (wr_data[31:18] == '0) && (h_len != '0) &&
                     (h_len <= LEN_LIM) && (wr_data[17:10] == seq);
  wire       take  = wr_en && !full && !err;
  wire       store = take && (ph == S_PAY || (ph == S_HDR && h_ok));

  assign used     = wr_ptr - rd_ptr;
  assign full     = used >= FULL_AT;
  assign low      = used <= LOW_MAX;
  assign rd_valid = !err && (rd_ptr != cm_ptr);
  assign rd_data  = mem[rd_ptr[AW-1:0]];
  assign crc_nx   = crc_word((ph == S_HDR) ? 32'hFFFFFFFF : crc, wr_data);

  always_ff @(posedge clk)
    if (store) mem[wr_ptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!load) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cm_ptr <= '0;
      rem    <= '0;
      seq    <= '0;
      crc    <= '0;
      ph     <= S_HDR;
      err    <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) rd_ptr <= rd_ptr + 1'b1;
      if ((rd_ready && !rd_valid) || (wr_en && full)) err <= 1'b1;
      if (take) begin
        case (ph)
          S_HDR: begin
            if (h_ok) begin
              wr_ptr <= wr_ptr + 1'b1;
              crc    <= crc_nx;
              rem    <= h_len[LW-1:0];
              ph     <= S_PAY;
            end else err <= 1'b1;
          end
          S_PAY: begin
            wr_ptr <= wr_ptr + 1'b1;
            crc    <= crc_nx;
            rem    <= rem - 1'b1;
            if (rem == LW'(1)) ph <= S_CHK;
          end
          default: begin
            ph <= S_HDR;
            if (wr_data == ~crc) begin
              cm_ptr <= wr_ptr;
              seq    <= seq + 1'b1;
            end else begin
              err    <= 1'b1;
              wr_ptr <= cm_ptr;
            end
          end
        endcase
      end
    end
  end
endmodule

module cfg_pkt_fifo_chk (
  input logic        clk,
  input logic        load,
  input logic        wr_en,
  input logic        rd_ready,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        full,
  input logic        low,
  input logic        err
);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!load) err |=> err);
  a_r9_no_valid_on_err: assert property (@(posedge clk) disable iff (!load) err |-> !rd_valid);
  a_r8_underflow: assert property (@(posedge clk) disable iff (!load) (rd_ready && !rd_valid) |=> err);
  a_r6_overflow: assert property (@(posedge clk) disable iff (!load) (wr_en && full) |=> err);
  a_r6_full_not_low: assert property (@(posedge clk) disable iff (!load) full |-> !low);
  a_r5_hold: assert property (@(posedge clk) disable iff (!load)
    (rd_valid && !rd_ready) |=> (err || (rd_valid && $stable(rd_data))));
  a_r10_clear: assert property (@(posedge clk) !load |=> (!err && !rd_valid && !full && low));
endmodule

bind cfg_pkt_fifo cfg_pkt_fifo_chk u_chk (
  .clk(clk), .load(load), .wr_en(wr_en), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .rd_data(rd_data), .full(full), .low(low), .err(err)
);

// File: tb/cfg_pkt_fifo_tb.sv
`timescale 1ns/1ps
module cfg_pkt_fifo_tb;
  logic        clk = 1'b0, load = 1'b0, wr_en = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic        full, low, rd_valid, err;
  logic [31:0] rd_data;

  cfg_pkt_fifo u_dut (.clk(clk), .load(load), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .low(low), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .err(err));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit run = 0, auto_rd = 0, force_rd = 0, done = 0;

  // reference model
  bit [31:0] q[$];
  bit [31:0] pkt[$];
  int  m_comm = 0, m_rem = 0, m_ph = 0;
  bit  m_err = 0;
  bit [7:0]  m_seq = 0;
  bit [31:0] m_crc = 0;

  function automatic bit [31:0] ref_crc(bit [31:0] c, bit [31:0] w);
    for (int b = 0; b < 4; b++) begin
      c ^= {24'h0, w[8*b +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  always @(posedge clk) begin
    if (!load) begin
      q.delete(); m_comm = 0; m_err = 0; m_seq = 0; m_ph = 0; m_rem = 0;
    end else begin
      bit oe, v, ne;
      int used;
      oe = m_err; used = q.size(); v = !oe && m_comm > 0; ne = oe;
      if (rd_ready && v) begin void'(q.pop_front()); m_comm--; end
      if (rd_ready && !v) ne = 1;
      if (wr_en && used >= 1023) ne = 1;
      else if (wr_en && !oe) begin
        if (m_ph == 0) begin
          if (wr_data[31:18] == 0 && wr_data[9:0] >= 1 && wr_data[9:0] <= 511 && wr_data[17:10] == m_seq) begin
            q.push_back(wr_data); m_crc = ref_crc(32'hFFFFFFFF, wr_data);
            m_rem = int'(wr_data[9:0]); m_ph = 1;
          end else ne = 1;
        end else if (m_ph == 1) begin
          q.push_back(wr_data); m_crc = ref_crc(m_crc, wr_data);
          m_rem--; if (m_rem == 0) m_ph = 2;
        end else begin
          m_ph = 0;
          if (wr_data == ~m_crc) begin m_comm = q.size(); m_seq++; end
          else begin ne = 1; while (q.size() > m_comm) void'(q.pop_back()); end
        end
      end
      m_err = ne;
    end
  end

  task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) fail(tag, what, act, exp);
  endtask

  always @(negedge clk) if (run && !done) begin
    bit ev;
    ev = !m_err && m_comm > 0;
    chk("R5", "rd_valid", 32'(rd_valid), 32'(ev));
    if (ev) chk("R3", "rd_data", rd_data, q[0]);
    chk("R6", "full", 32'(full), 32'(q.size() >= 1023));
    chk("R7", "low", 32'(low), 32'(q.size() <= 512));
    chk("R9", "err", 32'(err), 32'(m_err));
  end

  initial forever begin
    @(negedge clk); #1;
    rd_ready = force_rd || (auto_rd && rd_valid);
  end

  task automatic put(bit [31:0] w);
    @(negedge clk); #1; wr_en = 1'b1; wr_data = w;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; wr_en = 1'b0; end
  endtask
  task automatic build(int s, int len, bit bad);
    bit [31:0] c;
    pkt.delete();
    pkt.push_back({14'h0, 8'(s), 10'(len)});
    for (int i = 0; i < len; i++) pkt.push_back($urandom);
    c = 32'hFFFFFFFF;
    foreach (pkt[i]) c = ref_crc(c, pkt[i]);
    pkt.push_back(~c ^ {31'h0, bad});
  endtask
  task automatic send(int s, int len, bit bad);
    build(s, len, bad);
    foreach (pkt[i]) put(pkt[i]);
    idle(1);
  endtask
  task automatic reload();
    @(negedge clk); #1; load = 1'b0; wr_en = 1'b0;
    idle(2);
    @(negedge clk); #1; load = 1'b1;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    run = 1;
    idle(1);
    chk("R10", "reset err", 32'(err), 0);
    chk("R10", "reset low", 32'(low), 1);
    @(negedge clk); #1; load = 1'b1;

    // R3: nothing readable before the check word
    build(0, 4, 0);
    for (int i = 0; i < 5; i++) put(pkt[i]);
    idle(1);
    chk("R3", "valid before check word", 32'(rd_valid), 0);
    put(pkt[5]); idle(1);
    chk("R3", "valid after check word", 32'(rd_valid), 1);
    chk("R5", "first word is header", rd_data, pkt[0]);
    auto_rd = 1;
    send(1, 1, 0); send(2, 7, 0);
    idle(12);
    chk("R5", "drained", 32'(rd_valid), 0);

    // R1: wrap of the sequence number
    reload();
    for (int i = 0; i < 257; i++) send(i % 256, 1, 0);
    idle(4);
    chk("R1", "no err across wrap", 32'(err), 0);
    send(2, 1, 0);
    chk("R1", "wrong sequence", 32'(err), 1);

    // R1: first packet must be 0
    reload();
    send(1, 2, 0);
    chk("R1", "first seq not 0", 32'(err), 1);

    // R2: bad length and upper bits
    reload();
    put(32'h0000_0000); idle(1);
    chk("R2", "zero length", 32'(err), 1);
    reload();
    put(32'h8000_0003); idle(1);
    chk("R2", "upper bit set", 32'(err), 1);

    // R4/R9: bad check word rewinds and blocks
    reload();
    auto_rd = 0;
    send(0, 3, 0);
    chk("R5", "good packet offered", 32'(rd_valid), 1);
    send(1, 511, 1);
    chk("R4", "err on crc", 32'(err), 1);
    chk("R4", "space released", 32'(low), 1);
    chk("R9", "forwarding blocked", 32'(rd_valid), 0);
    send(1, 2, 0);
    chk("R9", "err sticky", 32'(err), 1);

    // R10: reload clears and accepts seq 0 again
    reload();
    chk("R10", "err cleared", 32'(err), 0);
    send(0, 2, 0);
    chk("R10", "fresh transfer accepted", 32'(rd_valid), 1);

    // R6/R7: two maximum packets without reading
    reload();
    send(0, 511, 0);
    chk("R7", "low at 512 stored", 32'(low), 1);
    put({14'h0, 8'd1, 10'd511}); idle(1);
    chk("R7", "low drops at 513", 32'(low), 0);
    for (int i = 0; i < 510; i++) put($urandom);
    idle(1);
    chk("R6", "full at 1023", 32'(full), 1);
    chk("R6", "no err yet", 32'(err), 0);
    put(32'h1234_5678); idle(1);
    chk("R6", "overflow err", 32'(err), 1);

    // R8: underflow
    reload();
    @(negedge clk); #1; force_rd = 1;
    @(negedge clk); #1; force_rd = 0;
    idle(1);
    chk("R8", "underflow err", 32'(err), 1);

    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule